// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Register Bank

This block is the shared register bank of a DMA controller serving up to twelve channels. Software reaches it over a plain 32-bit word read/write port. It keeps a 3-bit setting for each channel: a 2-bit transfer mode and a direction bit. It also keeps one interrupt-enable bit per channel. It drives the mode and direction of every channel onto dedicated outputs.

Each channel returns a completion pulse, an error pulse and a live 2-bit activity state. The bank latches the pulses into sticky flags that software clears by writing 1 to them. It shows those flags next to the live states in two status words. It raises a single interrupt line whenever a flagged channel is also enabled. The low eight channels and the upper four live in separate control and status words. A driver decodes fixed bit positions, so the positions below are part of the behaviour.

Top module: `dma_global_regs`

## Requirements
- R1: After a synchronous active-low reset, every mode, direction, enable, done flag and error flag is 0, `irq_o` is low, and every register reads zero except the live state fields.
- R2: Channel n below 8 keeps its mode in control word 0x00 bits [4n+1:4n] and its direction at bit 4n+2. Channel n from 8 to 11 uses word 0x0C at 4(n-8) in the same layout. A write updates `ch_mode_o[2n+1:2n]` and `ch_dir_o[n]` from the next cycle, and the field reads back. Bit 3 of each 4-bit field reads 0.
- R3: Interrupt enables sit in word 0x08: bit n for channels 0 to 7 and bit n+8 for channels 8 to 11. Every other bit of that word reads 0.
- R4: A completion pulse on `ch_done_i[n]` sets the done flag of channel n from the next cycle. The flag reads at status word 0x10 bit n for n below 8, and at status word 0x18 bit n-8 otherwise.
- R5: An error pulse on `ch_err_i[n]` sets the error flag of channel n, which reads at 0x10 bit n+8 or 0x18 bit n. The same pulse also sets that channel's done flag.
- R6: Writing 1 to a flag bit in its status word clears it. Writing 0 leaves it unchanged. Writing back a word just read clears every flag that word showed.
- R7: When a pulse that sets a flag arrives in the same cycle as a write that clears it, the flag stays set.
- R8: The live state of channel n reads at 0x10 bits [17+2n:16+2n] for n below 8, and at 0x18 bits [17+2(n-8):16+2(n-8)] otherwise. Writes to these bits have no effect.
- R9: `irq_o` is high exactly while some channel has both its done flag and its enable bit set. An error flag alone does not raise it.
- R10: Offsets 0x04, 0x14, 0x1C and any unaligned address read zero. Writes to them change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 5 | Byte address of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ch_state_i | input | 2*NUM_CH | Live 2-bit state of each channel |
| ch_done_i | input | NUM_CH | Completion pulse per channel |
| ch_err_i | input | NUM_CH | Error pulse per channel |
| ch_mode_o | output | 2*NUM_CH | Transfer mode per channel |
| ch_dir_o | output | NUM_CH | Direction per channel |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench sweeps every channel through the split between the low and high register words. A design that mixed up the low/high split, or the n+8 enable offset, would show a flag or enable at the wrong bit position, or drive the wrong channel's mode. The bench also makes a completion pulse coincide with a clearing write. A design that gave the clear priority would lose that completion and leave the channel's interrupt unseen. Further checks write back each status word as it was read, write 0 to flag positions, write all ones to the state fields and the unused words, and pulse errors with enables cleared. These catch clears that hit too many or too few flags, writable state bits, and an interrupt that fires without an enabled done flag.

// File: rtl/dgr_pkg.sv
// Shared constants, types and bit-position helpers for the DMA register bank.
// Assumes at most 12 channels: 8 in the low word group, 4 in the high group.
package dgr_pkg;
    localparam int unsigned DW        = 32;
    localparam int unsigned AW        = 5;
    localparam int          LOW_GROUP = 8;

    localparam logic [AW-1:0] A_CTL_LO  = 5'h00;
    localparam logic [AW-1:0] A_CTL_AUX = 5'h04;
    localparam logic [AW-1:0] A_IEN     = 5'h08;
    localparam logic [AW-1:0] A_CTL_HI  = 5'h0C;
    localparam logic [AW-1:0] A_STS_LO  = 5'h10;
    localparam logic [AW-1:0] A_STS_AUX = 5'h14;
    localparam logic [AW-1:0] A_STS_HI  = 5'h18;

    typedef struct packed {
        logic       dir;
        logic [1:0] mode;
    } chan_cfg_t;

    // True when a channel lives in the high register group.
    function automatic logic in_high(input int ch);
        return ch >= LOW_GROUP;
    endfunction

    // Lowest bit of the channel's 4-bit field in its control word.
    function automatic logic [4:0] cfg_lsb(input int ch);
        return 5'((ch < LOW_GROUP) ? 4 * ch : 4 * (ch - LOW_GROUP));
    endfunction

    // Position of the channel's enable in the enable word.
    function automatic logic [4:0] ien_bit(input int ch);
        return 5'((ch < LOW_GROUP) ? ch : ch + 8);
    endfunction

    // Position of the done flag in the channel's status word.
    function automatic logic [4:0] done_bit(input int ch);
        return 5'((ch < LOW_GROUP) ? ch : ch - LOW_GROUP);
    endfunction

    // Position of the error flag in the channel's status word.
    function automatic logic [4:0] err_bit(input int ch);
        return 5'((ch < LOW_GROUP) ? ch + 8 : ch);
    endfunction

    // Lowest bit of the live state field in the channel's status word.
    function automatic logic [4:0] state_lsb(input int ch);
        return 5'((ch < LOW_GROUP) ? 16 + 2 * ch : 16 + 2 * (ch - LOW_GROUP));
    endfunction
endpackage

// File: rtl/dgr_cfg_store.sv
// Holds the mode, direction and interrupt enable of every channel.
// Assumes word-addressed writes. Each channel picks its control word by group.
module dgr_cfg_store
    import dgr_pkg::*;
#(
    parameter int unsigned NUM_CH = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    output chan_cfg_t [NUM_CH-1:0] cfg_q,
    output logic [NUM_CH-1:0]      ien_q
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [AW-1:0] HOME = in_high(ch) ? A_CTL_HI : A_CTL_LO;
        chan_cfg_t cfg_r;
        logic      ien_r;

        // Capture this channel's mode and direction field on a write to its control word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_r <= '0;
            end else if (wr_en && wr_addr == HOME) begin
                cfg_r <= wr_data[cfg_lsb(ch) +: 3];
            end
        end

        // Capture this channel's interrupt enable on a write to the enable word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ien_r <= 1'b0;
            end else if (wr_en && wr_addr == A_IEN) begin
                ien_r <= wr_data[ien_bit(ch)];
            end
        end

        assign cfg_q[ch] = cfg_r;
        assign ien_q[ch] = ien_r;
    end
endmodule

// File: rtl/dgr_flag_cell.sv
// Sticky done and error flags of one channel, cleared by writing 1.
// Assumes single-cycle pulses. A setting pulse wins over a clear in the same cycle.
module dgr_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic done_pulse,
    input  logic err_pulse,
    input  logic clr_done,
    input  logic clr_err,
    output logic done_q,
    output logic err_q
);
    // Done flag: set by completion or error, cleared by write-1 unless set in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (done_pulse || err_pulse) begin
            done_q <= 1'b1;
        end else if (clr_done) begin
            done_q <= 1'b0;
        end
    end

    // Error flag: set by error, cleared by write-1 unless set in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_pulse) begin
            err_q <= 1'b1;
        end else if (clr_err) begin
            err_q <= 1'b0;
        end
    end
endmodule

// File: rtl/dgr_read_mux.sv
// Assembles the readable words from channel state and selects one by address.
// Assumes combinational read. Unused bits and unknown offsets read zero.
module dgr_read_mux
    import dgr_pkg::*;
#(
    parameter int unsigned NUM_CH = 12
) (
    input  logic [AW-1:0]          rd_addr,
    input  chan_cfg_t [NUM_CH-1:0] cfg_i,
    input  logic [NUM_CH-1:0]      ien_i,
    input  logic [NUM_CH-1:0]      done_i,
    input  logic [NUM_CH-1:0]      err_i,
    input  logic [2*NUM_CH-1:0]    state_i,
    output logic [DW-1:0]          rd_data
);
    logic [DW-1:0] w_ctl_lo, w_ctl_hi, w_ien, w_sts_lo, w_sts_hi;

    // Place every channel's fields at its bit positions in its word group.
    always_comb begin
        w_ctl_lo = '0;
        w_ctl_hi = '0;
        w_ien    = '0;
        w_sts_lo = '0;
        w_sts_hi = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            w_ien[ien_bit(ch)] = ien_i[ch];
            if (in_high(ch)) begin
                w_ctl_hi[cfg_lsb(ch) +: 3]   = cfg_i[ch];
                w_sts_hi[done_bit(ch)]       = done_i[ch];
                w_sts_hi[err_bit(ch)]        = err_i[ch];
                w_sts_hi[state_lsb(ch) +: 2] = state_i[2*ch +: 2];
            end else begin
                w_ctl_lo[cfg_lsb(ch) +: 3]   = cfg_i[ch];
                w_sts_lo[done_bit(ch)]       = done_i[ch];
                w_sts_lo[err_bit(ch)]        = err_i[ch];
                w_sts_lo[state_lsb(ch) +: 2] = state_i[2*ch +: 2];
            end
        end
    end

    // Select the addressed word.
    always_comb begin
        case (rd_addr)
            A_CTL_LO: rd_data = w_ctl_lo;
            A_IEN:    rd_data = w_ien;
            A_CTL_HI: rd_data = w_ctl_hi;
            A_STS_LO: rd_data = w_sts_lo;
            A_STS_HI: rd_data = w_sts_hi;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dma_global_regs.sv
// Shared control and interrupt register bank for a DMA controller of up to 12 channels.
// Assumes NUM_CH between 1 and 12, single-cycle channel pulses and a combinational read.
module dma_global_regs
    import dgr_pkg::*;
#(
    parameter int unsigned NUM_CH = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wen,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    input  logic [2*NUM_CH-1:0] ch_state_i,
    input  logic [NUM_CH-1:0]   ch_done_i,
    input  logic [NUM_CH-1:0]   ch_err_i,
    output logic [2*NUM_CH-1:0] ch_mode_o,
    output logic [NUM_CH-1:0]   ch_dir_o,
    output logic                irq_o
);
    chan_cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0]      irq_en;
    logic [NUM_CH-1:0]      flag_done;
    logic [NUM_CH-1:0]      flag_err;
    logic [NUM_CH-1:0]      clr_done;
    logic [NUM_CH-1:0]      clr_err;

    dgr_cfg_store #(.NUM_CH(NUM_CH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wen),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .cfg_q   (cfg),
        .ien_q   (irq_en)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [AW-1:0] STS_HOME = in_high(ch) ? A_STS_HI : A_STS_LO;

        assign clr_done[ch] = reg_wen && reg_addr == STS_HOME && reg_wdata[done_bit(ch)];
        assign clr_err[ch]  = reg_wen && reg_addr == STS_HOME && reg_wdata[err_bit(ch)];

        dgr_flag_cell u_flag (
            .clk        (clk),
            .rst_n      (rst_n),
            .done_pulse (ch_done_i[ch]),
            .err_pulse  (ch_err_i[ch]),
            .clr_done   (clr_done[ch]),
            .clr_err    (clr_err[ch]),
            .done_q     (flag_done[ch]),
            .err_q      (flag_err[ch])
        );

        assign ch_mode_o[2*ch +: 2] = cfg[ch].mode;
        assign ch_dir_o[ch]         = cfg[ch].dir;
    end

    dgr_read_mux #(.NUM_CH(NUM_CH)) u_rd (
        .rd_addr (reg_addr),
        .cfg_i   (cfg),
        .ien_i   (irq_en),
        .done_i  (flag_done),
        .err_i   (flag_err),
        .state_i (ch_state_i),
        .rd_data (reg_rdata)
    );

    assign irq_o = |(flag_done & irq_en);
endmodule

// File: rtl/dgr_checker.sv
// Temporal checks on the register bank, attached to every instance by bind.
// Assumes the same NUM_CH as the bound instance.
module dgr_checker
    import dgr_pkg::*;
#(
    parameter int unsigned NUM_CH = 12
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wen,
    input logic [AW-1:0]       reg_addr,
    input logic [DW-1:0]       reg_wdata,
    input logic [NUM_CH-1:0]   ch_done_i,
    input logic [NUM_CH-1:0]   ch_err_i,
    input logic [2*NUM_CH-1:0] ch_mode_o,
    input logic [NUM_CH-1:0]   ch_dir_o,
    input logic                irq_o,
    input logic [NUM_CH-1:0]   flag_done,
    input logic [NUM_CH-1:0]   flag_err,
    input logic [NUM_CH-1:0]   irq_en
);
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [AW-1:0] STS_HOME = in_high(ch) ? A_STS_HI : A_STS_LO;

        assert_done_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ch_done_i[ch] |=> flag_done[ch]);

        assert_err_sets_both_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ch_err_i[ch] |=> (flag_done[ch] && flag_err[ch]));

        assert_w1c_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wen && reg_addr == STS_HOME && reg_wdata[done_bit(ch)]
             && !ch_done_i[ch] && !ch_err_i[ch]) |=> !flag_done[ch]);

        assert_flag_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!ch_done_i[ch] && !ch_err_i[ch]
             && !(reg_wen && reg_addr == STS_HOME)) |=> ($stable(flag_done[ch]) && $stable(flag_err[ch])));

        assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wen && reg_addr == STS_HOME && reg_wdata[done_bit(ch)] && ch_done_i[ch])
            |=> flag_done[ch]);
    end

    assert_cfg_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wen && (reg_addr == A_CTL_LO || reg_addr == A_CTL_HI))
        |=> ($stable(ch_mode_o) && $stable(ch_dir_o)));

    assert_ien_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wen && reg_addr == A_IEN) |=> $stable(irq_en));

    assert_irq_has_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past((|(ch_done_i | ch_err_i)) || (reg_wen && reg_addr == A_IEN)));
endmodule

bind dma_global_regs dgr_checker #(.NUM_CH(NUM_CH)) i_dgr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wen   (reg_wen),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .ch_done_i (ch_done_i),
    .ch_err_i  (ch_err_i),
    .ch_mode_o (ch_mode_o),
    .ch_dir_o  (ch_dir_o),
    .irq_o     (irq_o),
    .flag_done (flag_done),
    .flag_err  (flag_err),
    .irq_en    (irq_en)
);

// File: tb/test_dma_global_regs.sv
// Sweeps all channels of the register bank against an arithmetic model built from the requirements.
module test_dma_global_regs;
    localparam int NCH        = 12;
    localparam int CLK_PERIOD = 10;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wen = 1'b0;
    logic [4:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [2*NCH-1:0] ch_state_i = '0;
    logic [NCH-1:0]   ch_done_i = '0;
    logic [NCH-1:0]   ch_err_i = '0;
    logic [2*NCH-1:0] ch_mode_o;
    logic [NCH-1:0]   ch_dir_o;
    logic             irq_o;

    int checks = 0;
    int errors = 0;

    logic [1:0] m_mode [NCH];
    logic       m_dir  [NCH];
    logic       m_en   [NCH];
    logic       m_done [NCH];
    logic       m_err  [NCH];

    dma_global_regs #(.NUM_CH(NCH)) i_dma_global_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wen    (reg_wen),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .ch_state_i (ch_state_i),
        .ch_done_i  (ch_done_i),
        .ch_err_i   (ch_err_i),
        .ch_mode_o  (ch_mode_o),
        .ch_dir_o   (ch_dir_o),
        .irq_o      (irq_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        logic [31:0] r = '0;
        for (int c = 0; c < NCH; c++) begin
            int k = (c < 8) ? c : c - 8;
            logic [1:0] st = ch_state_i[2*c +: 2];
            case (a)
                5'h00: if (c < 8) r |= 32'({m_dir[c], m_mode[c]}) << (4 * k);
                5'h0C: if (c >= 8) r |= 32'({m_dir[c], m_mode[c]}) << (4 * k);
                5'h08: r |= 32'(m_en[c]) << ((c < 8) ? c : c + 8);
                5'h10: if (c < 8) r |= (32'(m_done[c]) << k) | (32'(m_err[c]) << (k + 8))
                                      | (32'(st) << (16 + 2 * k));
                5'h18: if (c >= 8) r |= (32'(m_done[c]) << k) | (32'(m_err[c]) << (k + 8))
                                       | (32'(st) << (16 + 2 * k));
                default: ;
            endcase
        end
        return r;
    endfunction

    task automatic rd_chk(input string tag, input logic [4:0] a);
        reg_wen  = 1'b0;
        reg_addr = a;
        #1;
        check($sformatf("%s read %h", tag, a), reg_rdata, exp_read(a));
    endtask

    task automatic check_all(input string tag);
        logic [2*NCH-1:0] em = '0;
        logic [NCH-1:0]   ed = '0;
        logic             ei = 1'b0;
        for (int a = 0; a < 32; a += 4) rd_chk(tag, 5'(a));
        rd_chk(tag, 5'h02);
        for (int c = 0; c < NCH; c++) begin
            em[2*c +: 2] = m_mode[c];
            ed[c] = m_dir[c];
            ei |= m_done[c] & m_en[c];
        end
        check($sformatf("%s mode out", tag), 32'(ch_mode_o), 32'(em));
        check($sformatf("%s dir out", tag), 32'(ch_dir_o), 32'(ed));
        check($sformatf("%s irq", tag), 32'(irq_o), 32'(ei));
    endtask

    // One clock with the given write and pulses, then the model advances.
    task automatic step(input logic wen, input logic [4:0] a, input logic [31:0] d,
                        input logic [NCH-1:0] dn, input logic [NCH-1:0] er);
        @(negedge clk);
        reg_wen = wen; reg_addr = a; reg_wdata = d; ch_done_i = dn; ch_err_i = er;
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            logic       hi = (c >= 8);
            int         k  = hi ? c - 8 : c;
            logic       sw = wen && a == (hi ? 5'h18 : 5'h10);
            if (dn[c] || er[c]) m_done[c] = 1'b1;
            else if (sw && d[k]) m_done[c] = 1'b0;
            if (er[c]) m_err[c] = 1'b1;
            else if (sw && d[k + 8]) m_err[c] = 1'b0;
            if (wen && a == (hi ? 5'h0C : 5'h00)) {m_dir[c], m_mode[c]} = d[4*k +: 3];
            if (wen && a == 5'h08) m_en[c] = d[hi ? c + 8 : c];
        end
        reg_wen = 1'b0; ch_done_i = '0; ch_err_i = '0;
    endtask

    function automatic logic [NCH-1:0] one(input int c);
        return NCH'(1) << c;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            m_mode[c] = '0; m_dir[c] = 0; m_en[c] = 0; m_done[c] = 0; m_err[c] = 0;
        end
        ch_state_i = 24'h9C_36E1;
        repeat (3) @(negedge clk);
        // R1: reset values, state fields live.
        check_all("R1 reset");
        rst_n = 1'b1;
        check_all("R1 after release");

        // R2: control word sweeps over both channel groups.
        for (int k = 0; k < 16; k++) begin
            logic [31:0] p = (32'(k) * 32'h9E3779B9) ^ (32'(k) << 7);
            step(1, 5'h00, p, '0, '0);
            step(1, 5'h0C, ~p, '0, '0);
            check_all("R2 ctl sweep");
        end

        // R3: enable word patterns, bits outside the enable positions read 0.
        for (int k = 0; k < 8; k++) begin
            step(1, 5'h08, (32'(k) * 32'h6F4A2D97) ^ 32'hA5A5_5A5A, '0, '0);
            check_all("R3 enable sweep");
        end

        // R4, R6, R9: per-channel done flag with all enables on.
        step(1, 5'h08, 32'hFFFF_FFFF, '0, '0);
        for (int c = 0; c < NCH; c++) begin
            int hs = (c < 8) ? 'h10 : 'h18;
            int k  = (c < 8) ? c : c - 8;
            step(0, 5'h00, '0, one(c), '0);
            check_all("R4 done sets");
            step(1, 5'(hs), ~(32'h1 << k) & 32'h0000_FFFF, '0, '0);
            check_all("R6 write 0 keeps");
            step(1, 5'(hs), 32'h1 << k, '0, '0);
            check_all("R6 write 1 clears");
        end

        // R9: interrupt needs both flag and enable; error flag alone never raises it.
        step(1, 5'h08, '0, '0, '0);
        step(0, 5'h00, '0, one(3) | one(10), '0);
        check_all("R9 no enable");
        step(1, 5'h08, 32'h0000_0004, '0, '0);
        check_all("R9 other enable");
        step(1, 5'h08, 32'h0004_0000, '0, '0);
        check_all("R9 enable ch10");
        step(1, 5'h08, 32'h0000_0008, '0, '0);
        check_all("R9 enable ch3");
        step(1, 5'h10, 32'h0000_0008, '0, '0);
        step(1, 5'h18, 32'h0000_0004, '0, '0);
        check_all("R9 cleared");

        // R5, R6: error pulses set both flags, write-back clears what was read.
        for (int c = 0; c < NCH; c++) begin
            logic [4:0] hs = (c < 8) ? 5'h10 : 5'h18;
            logic [31:0] seen;
            step(0, 5'h00, '0, '0, one(c));
            check_all("R5 err sets both");
            reg_addr = hs; #1; seen = reg_rdata;
            step(1, hs, seen, '0, '0);
            check_all("R6 write back clears");
        end

        // R7: set pulse collides with a clearing write on the same flag.
        step(1, 5'h08, 32'hFFFF_FFFF, '0, '0);
        for (int c = 0; c < NCH; c++) begin
            logic [4:0] hs = (c < 8) ? 5'h10 : 5'h18;
            int k = (c < 8) ? c : c - 8;
            step(0, 5'h00, '0, one(c), one(c));
            step(1, hs, (32'h1 << k) | (32'h1 << (k + 8)), one(c), '0);
            check_all("R7 done beats clear");
            step(1, hs, (32'h1 << k) | (32'h1 << (k + 8)), '0, one(c));
            check_all("R7 err beats clear");
            step(1, hs, 32'h0000_FFFF, '0, '0);
        end

        // R6: many flags at once, each status word written back as read.
        step(0, 5'h00, '0, 12'hA5F, 12'h3C1);
        check_all("R6 multi set");
        for (int w = 0; w < 2; w++) begin
            logic [4:0] hs = (w == 0) ? 5'h10 : 5'h18;
            logic [31:0] seen;
            reg_addr = hs; #1; seen = reg_rdata;
            step(1, hs, seen, '0, '0);
            check_all("R6 multi write back");
        end

        // R8: live state patterns, and writes to the state bits have no effect.
        for (int k = 0; k < 4; k++) begin
            ch_state_i = 24'(32'(k + 1) * 32'h00B7_1D35);
            check_all("R8 state live");
        end
        step(1, 5'h10, 32'hFFFF_0000, '0, '0);
        step(1, 5'h18, 32'hFFFF_0000, '0, '0);
        check_all("R8 state write ignored");

        // R10: unused and unaligned offsets ignore writes and read zero.
        step(1, 5'h00, 32'h3625_1437, '0, '0);
        step(1, 5'h0C, 32'h0000_2516, '0, '0);
        step(0, 5'h00, '0, 12'h0F0, '0);
        step(1, 5'h04, 32'hFFFF_FFFF, '0, '0);
        step(1, 5'h14, 32'hFFFF_FFFF, '0, '0);
        step(1, 5'h1C, 32'hFFFF_FFFF, '0, '0);
        step(1, 5'h02, 32'hFFFF_FFFF, '0, '0);
        step(1, 5'h12, 32'hFFFF_FFFF, '0, '0);
        check_all("R10 unused writes");

        summary();
        $finish;
    end
endmodule